// File: doc/BRIEF.md
# Programmable Chip-Select and Wait-State Generator

This block decodes the address of an external bus master into four active-low chip selects and stretches each access with wait states. Every select owns a region that software sets as a lower and an upper bound. It also has a space bit, so the region is matched either against memory requests or against I/O requests. Memory regions are coarse and compare the top address byte, giving 64 KB granules. I/O regions compare the middle address byte, giving 256-byte sections. When regions overlap, the lowest-numbered select wins, so at most one select is ever driven.

Each select also carries its own internal wait-state count. When a request starts, the count of the winning select is loaded, and the ready output stays low until that count runs out. After that, an external hold input, brought into the clock domain through a synchronizer, can stretch the access further. The bus master keeps its request strobe high until it sees ready, then drops the strobe before it starts the next access.

Top module: `csel_wait_gen`

## Requirements
- R1: A select whose enable bit `cfg_en[i]` is 0 never drives `sel_n[i]` low, whatever the address and strobes.
- R2: A select with `cfg_io[i]`=0 (memory space) matches when `mem_req` is 1 and address bits [23:16] lie between `cfg_lo[8i+:8]` and `cfg_hi[8i+:8]`, both bounds inclusive.
- R3: A select with `cfg_io[i]`=1 (I/O space) matches when `io_req` is 1 and address bits [15:8] lie between its bounds, both inclusive. Address bits [23:16] play no part in this comparison.
- R4: Selects are active-low and combinational from the inputs. A memory-space select ignores `io_req`, an I/O-space select ignores `mem_req`, and with both strobes low all of `sel_n` is 1.
- R5: When several selects match, only the lowest-numbered one is driven low, so at most one bit of `sel_n` is 0.
- R6: An access begins at the first clock edge that samples a strobe high after both were low. The winner's 3-bit count w (`cfg_wait[3i+:3]`) is loaded at that edge, and `ready` goes to 1 after edge w+1. An access that hits no region uses w=0.
- R7: `ext_hold` (active high) passes through two flops. It is looked at only once the internal count is 0. While the synchronized copy is 1, `ready` stays 0. After a release, `ready` rises after the second edge.
- R8: `ready` is 0 whenever both strobes are low. A new access, with a freshly loaded count, needs the strobes to have gone low first.
- R9: During and directly after the synchronous active-low reset, `ready` is 0. With no strobe active, every select is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 24 | Bus address |
| mem_req | input | 1 | Memory request strobe, active high |
| io_req | input | 1 | I/O request strobe, active high |
| cfg_en | input | 4 | Per-select enable |
| cfg_io | input | 4 | Per-select space: 0 memory, 1 I/O |
| cfg_lo | input | 32 | Per-select lower bound, 8 bits each |
| cfg_hi | input | 32 | Per-select upper bound, 8 bits each |
| cfg_wait | input | 12 | Per-select wait count, 3 bits each |
| ext_hold | input | 1 | External wait request, active high, asynchronous |
| sel_n | output | 4 | Chip selects, active low |
| ready | output | 1 | Access may complete |

## Verification
The bench uses the default build: four selects, a 24-bit address, 3-bit wait counts and a two-flop hold synchronizer. With these values the full wait range from 0 to 7 can be reached in a few cycles each, and every select can be set up at once. Two memory regions overlap and two I/O regions overlap, so the priority rule and the inclusive bounds are both hit at their edges. The 3-bit count also lets the bench check the exact hold release latency on top of an already elapsed internal count.

// File: rtl/csel_pkg.sv
// Package: shared constants and the space encoding of the chip-select block.
// Assumes the address is at least 16 bits wide so both fields exist.
package csel_pkg;
    localparam int FIELD_W = 8;   // width of a region bound
    localparam int IO_LSB  = 8;   // I/O field starts at address bit 8

    typedef enum logic {
        SPACE_MEM = 1'b0,
        SPACE_IO  = 1'b1
    } space_e;
endpackage

// File: rtl/csel_region_match.sv
// Region matcher: one chip-select comparator.
// Picks the memory or I/O address field by the space bit and checks that
// it lies within the inclusive bounds, qualified by the matching strobe.
// Assumes lo <= hi for a useful region; an inverted range never hits.
module csel_region_match
    import csel_pkg::*;
(
    input  logic               en,
    input  space_e             space,
    input  logic               mem_req,
    input  logic               io_req,
    input  logic [FIELD_W-1:0] mem_field,
    input  logic [FIELD_W-1:0] io_field,
    input  logic [FIELD_W-1:0] lo,
    input  logic [FIELD_W-1:0] hi,
    output logic               hit
);
    logic [FIELD_W-1:0] field;
    logic               strobe;

    // Choose the compared field and the strobe that qualifies it.
    always_comb begin
        if (space == SPACE_IO) begin
            field  = io_field;
            strobe = io_req;
        end else begin
            field  = mem_field;
            strobe = mem_req;
        end
    end

    // Inclusive bounds comparison gated by enable and strobe.
    always_comb begin
        hit = en && strobe && (field >= lo) && (field <= hi);
    end
endmodule

// File: rtl/csel_priority.sv
// Fixed-priority picker: the lowest-numbered active request wins.
// Output is one-hot or all zero.
module csel_priority #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    // Scan upward and keep only the first set bit.
    always_comb begin
        logic taken;
        taken = 1'b0;
        grant = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !taken) begin
                grant[i] = 1'b1;
                taken    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/csel_wait_ctrl.sv
// Wait-state controller: counts the internal wait states of an access,
// then gates ready with a synchronized external hold.
// Assumes the strobe stays high until ready is seen. SYNC_STAGES >= 2.
module csel_wait_ctrl #(
    parameter int WAIT_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [WAIT_W-1:0] load_val,
    input  logic              ext_hold,
    output logic              ready
);
    logic [SYNC_STAGES-1:0] hold_sync;
    logic                   active;
    logic [WAIT_W-1:0]      cnt;

    // Bring the asynchronous hold input into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) hold_sync <= '0;
        else        hold_sync <= {hold_sync[SYNC_STAGES-2:0], ext_hold};
    end

    // Track the access and count down its internal wait states.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (!req) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (!active) begin
            active <= 1'b1;
            cnt    <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Ready once the count is spent and no hold is seen.
    always_comb begin
        ready = req && active && (cnt == '0) && !hold_sync[SYNC_STAGES-1];
    end
endmodule

// File: rtl/csel_wait_gen.sv
// Top: four-way programmable chip-select decoder with per-select wait states.
// Each select compares either the memory field (top byte) or the I/O field
// (bits IO_LSB up) against its bounds. The lowest index wins, and the
// winner's wait count is loaded at the start of each access.
// Assumes the configuration is static while an access is in flight.
module csel_wait_gen
    import csel_pkg::*;
#(
    parameter int N_SEL       = 4,
    parameter int ADDR_W      = 24,
    parameter int WAIT_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      mem_req,
    input  logic                      io_req,
    input  logic [N_SEL-1:0]          cfg_en,
    input  logic [N_SEL-1:0]          cfg_io,
    input  logic [N_SEL*FIELD_W-1:0]  cfg_lo,
    input  logic [N_SEL*FIELD_W-1:0]  cfg_hi,
    input  logic [N_SEL*WAIT_W-1:0]   cfg_wait,
    input  logic                      ext_hold,
    output logic [N_SEL-1:0]          sel_n,
    output logic                      ready
);
    localparam int MEM_LSB = ADDR_W - FIELD_W;

    logic [FIELD_W-1:0] mem_field;
    logic [FIELD_W-1:0] io_field;
    logic [N_SEL-1:0]   hits;
    logic [N_SEL-1:0]   grant;
    logic [WAIT_W-1:0]  wait_sel;
    logic               any_req;
    logic               unused_low;

    // Split the address into the two compared fields.
    always_comb begin
        mem_field  = addr[MEM_LSB +: FIELD_W];
        io_field   = addr[IO_LSB +: FIELD_W];
        unused_low = ^addr[IO_LSB-1:0];
        any_req    = mem_req || io_req;
    end

    // One comparator per chip select.
    for (genvar g = 0; g < N_SEL; g++) begin : g_match
        csel_region_match u_match (
            .en        (cfg_en[g]),
            .space     (space_e'(cfg_io[g])),
            .mem_req   (mem_req),
            .io_req    (io_req),
            .mem_field (mem_field),
            .io_field  (io_field),
            .lo        (cfg_lo[g*FIELD_W +: FIELD_W]),
            .hi        (cfg_hi[g*FIELD_W +: FIELD_W]),
            .hit       (hits[g])
        );
    end

    csel_priority #(.N(N_SEL)) u_prio (
        .req   (hits),
        .grant (grant)
    );

    // Pick the wait count of the winning select (zero when none).
    always_comb begin
        wait_sel = '0;
        for (int i = 0; i < N_SEL; i++) begin
            if (grant[i]) wait_sel = cfg_wait[i*WAIT_W +: WAIT_W];
        end
    end

    csel_wait_ctrl #(.WAIT_W(WAIT_W), .SYNC_STAGES(SYNC_STAGES)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (any_req),
        .load_val (wait_sel),
        .ext_hold (ext_hold),
        .ready    (ready)
    );

    // Drive the active-low selects.
    always_comb begin
        sel_n = ~grant;
    end
endmodule

// File: rtl/csel_wait_gen_chk.sv
// Checker: port-level properties of the chip-select block, bound to the top.
module csel_wait_gen_chk #(
    parameter int N_SEL = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mem_req,
    input logic             io_req,
    input logic [N_SEL-1:0] cfg_en,
    input logic             ext_hold,
    input logic [N_SEL-1:0] sel_n,
    input logic             ready
);
    logic [1:0] since_rst;

    // Count cycles since reset, saturating, so history checks start late.
    always_ff @(posedge clk) begin
        if (!rst_n)               since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    p_one_winner_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~sel_n));

    p_idle_no_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req || io_req) |-> (&sel_n));

    p_ready_needs_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (mem_req || io_req));

    p_start_not_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req || io_req) |-> !ready);

    p_hold_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) && ext_hold && $past(ext_hold) && $past(ext_hold, 2)
        |-> !ready);

    for (genvar g = 0; g < N_SEL; g++) begin : g_dis
        p_disabled_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_en[g] |-> sel_n[g]);
    end
endmodule

bind csel_wait_gen csel_wait_gen_chk #(.N_SEL(N_SEL)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_req  (mem_req),
    .io_req   (io_req),
    .cfg_en   (cfg_en),
    .ext_hold (ext_hold),
    .sel_n    (sel_n),
    .ready    (ready)
);

// File: tb/csel_wait_gen_test.sv
module csel_wait_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] addr = '0;
    logic        mem_req = 1'b0;
    logic        io_req = 1'b0;
    logic [3:0]  cfg_en = '0;
    logic [3:0]  cfg_io = '0;
    logic [31:0] cfg_lo = '0;
    logic [31:0] cfg_hi = '0;
    logic [11:0] cfg_wait = '0;
    logic        ext_hold = 1'b0;
    logic [3:0]  sel_n;
    logic        ready;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        string    tag;
        logic [3:0] exp_sel;
        int       exp_lat;
    } item_t;

    item_t q[$];
    bit    mon_done = 1'b0;

    always #4 clk = ~clk;

    csel_wait_gen uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .mem_req(mem_req), .io_req(io_req),
        .cfg_en(cfg_en), .cfg_io(cfg_io), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
        .cfg_wait(cfg_wait), .ext_hold(ext_hold), .sel_n(sel_n), .ready(ready)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Monitor: pop expected items, compare select and ready latency.
    initial begin
        forever begin
            wait (q.size() > 0);
            begin
                item_t it;
                int lat;
                it = q.pop_front();
                #1;
                check({it.tag, " select"}, 32'(sel_n), 32'(it.exp_sel));
                lat = 0;
                for (int k = 0; k < 40; k++) begin
                    @(negedge clk);
                    #1;
                    lat++;
                    if (ready) break;
                end
                check({it.tag, " latency"}, lat, it.exp_lat);
                mon_done = 1'b1;
            end
        end
    end

    // Driver: start an access, push its expectation, finish after the monitor.
    task automatic access(string tag, bit io, logic [23:0] a, logic [3:0] exp_sel,
                          int exp_lat, int release_at);
        @(negedge clk);
        addr     = a;
        mem_req  = !io;
        io_req   = io;
        mon_done = 1'b0;
        q.push_back('{tag, exp_sel, exp_lat});
        if (release_at > 0) begin
            fork
                begin
                    repeat (release_at) @(negedge clk);
                    ext_hold = 1'b0;
                end
            join_none
        end
        wait (mon_done);
        @(negedge clk);
        mem_req = 1'b0;
        io_req  = 1'b0;
        #1;
        check({tag, " R8 idle ready"}, 32'(ready), 0);
        check({tag, " R4 idle selects"}, 32'(sel_n), 32'hF);
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // sel0 mem 00..0F w1, sel1 mem 08..3F w3, sel2 io 10..1F w7, sel3 io 1F..20 w0
        cfg_en   = 4'b1111;
        cfg_io   = 4'b1100;
        cfg_lo   = {8'h1F, 8'h10, 8'h08, 8'h00};
        cfg_hi   = {8'h20, 8'h1F, 8'h3F, 8'h0F};
        cfg_wait = {3'd0, 3'd7, 3'd3, 3'd1};
        repeat (3) @(negedge clk);
        #1;
        check("R9 reset ready", 32'(ready), 0);
        check("R9 reset selects", 32'(sel_n), 32'hF);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check("R9 after reset ready", 32'(ready), 0);

        access("R2 R6 mem sel0",          1'b0, 24'h05_1234, 4'b1110, 2, 0);
        access("R2 upper bound sel0",     1'b0, 24'h0F_FFFF, 4'b1110, 2, 0);
        access("R2 R6 sel1 w3",           1'b0, 24'h10_0000, 4'b1101, 4, 0);
        access("R2 sel1 upper bound",     1'b0, 24'h3F_0000, 4'b1101, 4, 0);
        access("R6 no region w0",         1'b0, 24'h40_0000, 4'b1111, 1, 0);
        access("R5 mem overlap",          1'b0, 24'h0A_0000, 4'b1110, 2, 0);
        access("R3 R6 io sel2 w7",        1'b1, 24'h00_1000, 4'b1011, 8, 0);
        access("R5 io overlap",           1'b1, 24'h00_1F00, 4'b1011, 8, 0);
        access("R3 io sel3 w0",           1'b1, 24'h00_2000, 4'b0111, 1, 0);
        access("R3 io ignores top byte",  1'b1, 24'h05_0000, 4'b1111, 1, 0);
        access("R4 mem ignores io region",1'b0, 24'h50_1500, 4'b1111, 1, 0);
        access("R4 io ignores mem region",1'b1, 24'h20_0000, 4'b1111, 1, 0);

        cfg_en = 4'b1110;
        access("R1 disabled sel0",        1'b0, 24'h0A_0000, 4'b1101, 4, 0);
        access("R1 disabled no hit",      1'b0, 24'h05_0000, 4'b1111, 1, 0);
        cfg_en = 4'b1111;

        ext_hold = 1'b1;
        repeat (3) @(negedge clk);
        access("R7 hold release",         1'b0, 24'h20_0000, 4'b1101, 8, 6);
        access("R8 back to back",         1'b0, 24'h20_0000, 4'b1101, 4, 0);

        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule